// File: doc/BRIEF.md
# Data-Ready Flag Controller with Serial Read-Out

This block sits between a periodic conversion source and a simple serial read port. It keeps a holding data register and drives an active-low ready flag. When a scheduled output update arrives, the block moves the waiting conversion result into the data register and pulls the flag low. A complete serial read of the data word sends the flag high again. If nobody reads the word, the flag still goes high for a fixed blanking window before the next scheduled update. During that window no read should begin while the register may change. The same flag also reports that a calibration sequence has finished.

Conversion results come in on a valid/ready stream into a one-entry holding stage. `res_ready` is high only while that stage is empty. A result moves across on a clock where `res_valid` and `res_ready` are both high. While ready is low the source must keep `res_valid` high and `res_data` unchanged, and the result stays in place until it is taken.

A read starts on the falling edge of chip select. At that point one of four internal registers is loaded into the output shifter, and the register-select input picks which one. The bits leave MSB first. Each serial-clock falling edge seen while chip select is low moves the word on by one bit. Both serial inputs are sampled by the master clock.

Top module: `rdy_flag_ctrl`

## Requirements
- R1: After a synchronous active-high reset the flag `drdy_n` is 1, `res_ready` is 1, `ser_out` is 0, the data register is 0 and the update timer restarts at count 0.
- R2: At each scheduled update (the timer count equals PERIOD-1), a held result with no read in progress is copied into the data register, and `drdy_n` is 0 from the next cycle.
- R3: After the 16th serial-clock falling edge of a read of the data register, `drdy_n` goes to 1 in the next cycle.
- R4: When the timer count equals PERIOD-BLANK-1, `drdy_n` goes to 1. It therefore stays high for the BLANK (500 by default) cycles before the next update, even if nothing has read the word.
- R5: If chip select rises before all bits have been shifted, the read is aborted. An aborted read leaves `drdy_n` as it was.
- R6: If an update falls due while a read is in progress (chip select has gone low and the read has not ended), the data register is left unchanged. The held result is written in the first cycle after the read ends, and `drdy_n` goes low with that write.
- R7: A one-cycle pulse on `cal_done` drives `drdy_n` to 0 in the next cycle.
- R8: `reg_sel` is sampled at the chip-select falling edge. The codes are 0 for the communications register, 1 for setup and 2 for clock, each 8 bits wide, and 3 for the data register, which is 16 bits wide. Bits are shifted out MSB first, with the current bit on `ser_out`. Reading one of the 8-bit registers never changes `drdy_n`.
- R9: `res_ready` is 0 while a result is held. A result offered during that time waits and is accepted unchanged once the holding stage empties.
- R10: If no result is held when an update falls due, the data register and `drdy_n` stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_done | input | 1 | One-cycle pulse when calibration has finished |
| res_valid | input | 1 | A conversion result is offered |
| res_ready | output | 1 | The holding stage is empty and can take a result |
| res_data | input | DATA_W | Conversion result |
| reg_sel | input | 2 | Register chosen for the next read |
| comm_val | input | CTRL_W | Communications register contents |
| setup_val | input | CTRL_W | Setup register contents |
| clkcfg_val | input | CTRL_W | Clock register contents |
| ser_clk | input | 1 | Serial clock; the shifter advances on its falling edge |
| ser_csn | input | 1 | Active-low chip select |
| ser_out | output | 1 | Serial data out, MSB first |
| drdy_n | output | 1 | Active-low data-ready flag |

## Verification
The in-RTL assertions check on every cycle the rules that relate signals across adjacent cycles. The data register does not change during a read. A completed data read, a calibration pulse and the blanking-window start each move the flag. A stream handshake fills the holding stage. An abort ends a read. Ordering and content can only be shown by the bench scenarios, which compare against a cycle-by-cycle model. Those scenarios cover the exact bit sequence read back for each register code, the update that is deferred and then lands after a read crossing the update tick, a source held off by back-pressure until the next tick, and the update tick that has no result waiting.

// File: rtl/rdy_pkg.sv
package rdy_pkg;
  typedef enum logic [1:0] {
    SEL_COMM  = 2'd0,
    SEL_SETUP = 2'd1,
    SEL_CLOCK = 2'd2,
    SEL_DATA  = 2'd3
  } regsel_e;
endpackage

// File: rtl/upd_timer.sv
module upd_timer #(
  parameter int PERIOD = 1200,
  parameter int BLANK  = 500
) (
  input  logic clk,
  input  logic rst,
  output logic tick,
  output logic blank_start
);
  localparam int CW = $clog2(PERIOD);
  localparam logic [CW-1:0] LAST  = CW'(PERIOD - 1);
  localparam logic [CW-1:0] BSTRT = CW'(PERIOD - BLANK - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assign tick        = (cnt_q == LAST);
  assign blank_start = (cnt_q == BSTRT);

  // R4: the count restarts after each update tick
  assert_tick_restart_R4: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt_q == '0));
endmodule

// File: rtl/shift_out.sv
module shift_out
  import rdy_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              csn,
  input  logic [1:0]        sel_in,
  input  logic [CTRL_W-1:0] comm_v,
  input  logic [CTRL_W-1:0] setup_v,
  input  logic [CTRL_W-1:0] clkcfg_v,
  input  logic [DATA_W-1:0] data_v,
  output logic              sdo,
  output logic              busy,
  output logic              data_done
);
  localparam int BW = $clog2(DATA_W + 1);
  localparam int PAD = DATA_W - CTRL_W;

  logic              pscl_q, pcs_q, act_q;
  regsel_e           sel_q;
  logic [BW-1:0]     cnt_q;
  logic [DATA_W-1:0] sh_q, load_w;
  logic              cs_fall, sclk_fall, last;
  logic [BW-1:0]     lim;

  always_comb begin
    case (regsel_e'(sel_in))
      SEL_COMM:  load_w = {comm_v,   {PAD{1'b0}}};
      SEL_SETUP: load_w = {setup_v,  {PAD{1'b0}}};
      SEL_CLOCK: load_w = {clkcfg_v, {PAD{1'b0}}};
      default:   load_w = data_v;
    endcase
  end

  assign cs_fall   = pcs_q & ~csn;
  assign sclk_fall = pscl_q & ~sclk;
  assign lim       = (sel_q == SEL_DATA) ? BW'(DATA_W - 1) : BW'(CTRL_W - 1);
  assign last      = (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      pscl_q <= 1'b1;
      pcs_q  <= 1'b1;
      act_q  <= 1'b0;
      sel_q  <= SEL_COMM;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else begin
      pscl_q <= sclk;
      pcs_q  <= csn;
      if (cs_fall) begin
        act_q <= 1'b1;
        sel_q <= regsel_e'(sel_in);
        cnt_q <= '0;
        sh_q  <= load_w;
      end else if (csn) begin
        act_q <= 1'b0;
      end else if (act_q && sclk_fall) begin
        sh_q  <= sh_q << 1;
        cnt_q <= cnt_q + 1'b1;
        if (last) act_q <= 1'b0;
      end
    end
  end

  assign sdo       = act_q & sh_q[DATA_W-1];
  assign busy      = act_q | cs_fall;
  assign data_done = act_q & ~csn & sclk_fall & last & (sel_q == SEL_DATA);

  // R8: a chip-select falling edge always opens a read
  assert_read_opens_R8: assert property (@(posedge clk) disable iff (rst)
    cs_fall |=> act_q);
  // R5: raising chip select ends any read at once
  assert_abort_ends_R5: assert property (@(posedge clk) disable iff (rst)
    (act_q && csn) |=> !act_q);
endmodule

// File: rtl/flag_hold.sv
module flag_hold #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  output logic              res_ready,
  input  logic              tick,
  input  logic              blank_start,
  input  logic              cal_done,
  input  logic              busy,
  input  logic              data_done,
  output logic              drdy_n,
  output logic [DATA_W-1:0] dreg
);
  logic              pend_full_q, owed_q, drdy_q;
  logic [DATA_W-1:0] pend_q, dreg_q;
  logic              accept, go;

  assign res_ready = ~pend_full_q;
  assign accept    = res_valid & ~pend_full_q;
  assign go        = (tick | owed_q) & pend_full_q & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_full_q <= 1'b0;
      pend_q      <= '0;
      dreg_q      <= '0;
      owed_q      <= 1'b0;
      drdy_q      <= 1'b1;
    end else begin
      if (accept) begin
        pend_q      <= res_data;
        pend_full_q <= 1'b1;
      end
      if (go) begin
        dreg_q      <= pend_q;
        pend_full_q <= 1'b0;
        owed_q      <= 1'b0;
      end else if (tick && pend_full_q && busy) begin
        owed_q <= 1'b1;
      end
      if (go)                           drdy_q <= 1'b0;
      else if (cal_done)                drdy_q <= 1'b0;
      else if (data_done || blank_start) drdy_q <= 1'b1;
    end
  end

  assign drdy_n = drdy_q;
  assign dreg   = dreg_q;

  // R6: the data register is frozen while the shifter is busy
  assert_reg_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(dreg_q));
  // R2: a fresh register value always comes with the flag low
  assert_flag_low_on_update_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(dreg_q) |-> !drdy_q);
  // R9: an accepted result closes the stage to further input
  assert_accept_fills_R9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_ready) |=> !res_ready);
  // R3: a finished data read lifts the flag
  assert_read_lifts_R3: assert property (@(posedge clk) disable iff (rst)
    (data_done && !go && !cal_done) |=> drdy_q);
  // R4: entering the blanking window lifts the flag
  assert_blank_lifts_R4: assert property (@(posedge clk) disable iff (rst)
    (blank_start && !cal_done && !owed_q) |=> drdy_q);
  // R7: calibration completion pulls the flag low
  assert_cal_low_R7: assert property (@(posedge clk) disable iff (rst)
    cal_done |=> !drdy_q);
endmodule

// File: rtl/rdy_flag_ctrl.sv
module rdy_flag_ctrl #(
  parameter int DATA_W = 16,
  parameter int CTRL_W = 8,
  parameter int PERIOD = 1200,
  parameter int BLANK  = 500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cal_done,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [DATA_W-1:0] res_data,
  input  logic [1:0]        reg_sel,
  input  logic [CTRL_W-1:0] comm_val,
  input  logic [CTRL_W-1:0] setup_val,
  input  logic [CTRL_W-1:0] clkcfg_val,
  input  logic              ser_clk,
  input  logic              ser_csn,
  output logic              ser_out,
  output logic              drdy_n
);
  logic              tick, blank_start, busy, data_done;
  logic [DATA_W-1:0] dreg;

  upd_timer #(.PERIOD(PERIOD), .BLANK(BLANK)) u_tmr (
    .clk(clk), .rst(rst), .tick(tick), .blank_start(blank_start)
  );

  shift_out #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_sh (
    .clk(clk), .rst(rst), .sclk(ser_clk), .csn(ser_csn), .sel_in(reg_sel),
    .comm_v(comm_val), .setup_v(setup_val), .clkcfg_v(clkcfg_val),
    .data_v(dreg), .sdo(ser_out), .busy(busy), .data_done(data_done)
  );

  flag_hold #(.DATA_W(DATA_W)) u_fl (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
    .res_ready(res_ready), .tick(tick), .blank_start(blank_start),
    .cal_done(cal_done), .busy(busy), .data_done(data_done),
    .drdy_n(drdy_n), .dreg(dreg)
  );
endmodule

// File: tb/sim_rdy_flag_ctrl.sv
module sim_rdy_flag_ctrl;
  localparam int P  = 700;
  localparam int BL = 500;
  localparam logic [7:0] CV = 8'h1E, SV = 8'h6B, KV = 8'h0D;

  logic clk = 1'b0, rst = 1'b1, cal_done = 1'b0, res_valid = 1'b0;
  logic [15:0] res_data = '0;
  logic [1:0] reg_sel = 2'd0;
  logic ser_clk = 1'b1, ser_csn = 1'b1;
  logic res_ready, ser_out, drdy_n;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  rdy_flag_ctrl #(.DATA_W(16), .CTRL_W(8), .PERIOD(P), .BLANK(BL)) u0 (
    .clk(clk), .rst(rst), .cal_done(cal_done), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .reg_sel(reg_sel),
    .comm_val(CV), .setup_val(SV), .clkcfg_val(KV), .ser_clk(ser_clk),
    .ser_csn(ser_csn), .ser_out(ser_out), .drdy_n(drdy_n)
  );

  // behavioural reference model
  int m_cnt = 0, m_idx = 0, m_len = 8;
  logic m_flag = 1'b1, m_act = 1'b0, m_owed = 1'b0, m_pcs = 1'b1, m_pscl = 1'b1;
  logic m_isdata = 1'b0, started = 1'b0;
  logic [15:0] m_dreg = '0, m_word = '0;
  logic [15:0] pq[$];

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_cnt = 0; m_flag = 1; m_act = 0; m_owed = 0; m_pcs = 1; m_pscl = 1;
      m_dreg = '0; pq.delete();
    end else begin
      automatic logic csf = m_pcs && !ser_csn;
      automatic logic sf = m_pscl && !ser_clk;
      automatic logic bsy = m_act || csf;
      automatic logic tk = (m_cnt == P - 1);
      automatic logic bs = (m_cnt == P - BL - 1);
      automatic logic have = (pq.size() > 0);
      automatic logic go = (tk || m_owed) && have && !bsy;
      automatic logic dn = 0;
      if (go) m_owed = 0; else if (tk && have && bsy) m_owed = 1;
      if (csf) begin
        m_act = 1; m_idx = 0; m_isdata = (reg_sel == 2'd3);
        m_len = m_isdata ? 16 : 8;
        case (reg_sel)
          2'd0: m_word = {CV, 8'h00};
          2'd1: m_word = {SV, 8'h00};
          2'd2: m_word = {KV, 8'h00};
          default: m_word = m_dreg;
        endcase
      end else if (ser_csn) m_act = 0;
      else if (m_act && sf) begin
        m_idx++;
        if (m_idx == m_len) begin m_act = 0; dn = m_isdata; end
      end
      if (go) m_flag = 0;
      else if (cal_done) m_flag = 0;
      else if (dn || bs) m_flag = 1;
      if (go) m_dreg = pq.pop_front();
      if (res_valid && !have) pq.push_back(res_data);
      m_cnt = tk ? 0 : m_cnt + 1;
      m_pcs = ser_csn; m_pscl = ser_clk;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (started) begin
    chk("R2/R3/R4/R7 flag trace", drdy_n, m_flag);
    chk("R8 serial out trace", ser_out, m_act ? m_word[15 - m_idx] : 1'b0);
    chk("R9 ready trace", res_ready, pq.size() == 0);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_cnt(input int v);
    do @(negedge clk); while (m_cnt != v);
  endtask

  task automatic push(input logic [15:0] d);
    logic ok;
    res_valid = 1'b1; res_data = d;
    do begin ok = res_ready; @(negedge clk); end while (!ok);
    res_valid = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, input int nbits, output logic [15:0] v);
    v = '0; reg_sel = sel; ser_csn = 1'b0; cyc(2);
    for (int i = 0; i < nbits; i++) begin
      v = {v[14:0], ser_out};
      ser_clk = 1'b0; cyc(2);
      ser_clk = 1'b1; cyc(2);
    end
    ser_csn = 1'b1; cyc(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    cyc(4); rst = 1'b0; cyc(1);
    chk("R1 reset flag", drdy_n, 1);
    chk("R1 reset ready", res_ready, 1);
    chk("R1 reset sdo", ser_out, 0);
    rd(2'd3, 16, v);
    chk("R1 reset data register", v, 16'h0000);
    // R7 calibration done
    cal_done = 1'b1; cyc(1); cal_done = 1'b0;
    chk("R7 flag low after cal", drdy_n, 0);
    // R9 back-pressure and R2 update
    push(16'hA5C3);
    chk("R9 ready low while held", res_ready, 0);
    push(16'h3C96);
    chk("R2 flag low after update", drdy_n, 0);
    chk("R9 second result held", res_ready, 0);
    rd(2'd3, 16, v);
    chk("R2 data register value", v, 16'hA5C3);
    chk("R3 flag high after full read", drdy_n, 1);
    // next update: second result
    wait_cnt(1);
    chk("R2 second update flag low", drdy_n, 0);
    rd(2'd1, 8, v);
    chk("R8 setup register bits", v, {8'h00, SV});
    chk("R8 ctrl read keeps flag", drdy_n, 0);
    rd(2'd2, 8, v);
    chk("R8 clock register bits", v, {8'h00, KV});
    rd(2'd0, 8, v);
    chk("R8 comm register bits", v, {8'h00, CV});
    rd(2'd3, 5, v);
    chk("R5 aborted read keeps flag low", drdy_n, 0);
    wait_cnt(P - BL - 1);
    chk("R4 flag low before blanking", drdy_n, 0);
    wait_cnt(P - BL);
    chk("R4 flag high in blanking", drdy_n, 1);
    wait_cnt(P - 1);
    chk("R4 flag high at last blank cycle", drdy_n, 1);
    // R10 update with nothing held
    wait_cnt(2);
    chk("R10 no update keeps flag high", drdy_n, 1);
    rd(2'd3, 16, v);
    chk("R10 data register unchanged", v, 16'h3C96);
    // R6 deferred update
    push(16'h5A0F);
    wait_cnt(P - 5);
    rd(2'd3, 16, v);
    chk("R6 read across tick sees old word", v, 16'h3C96);
    chk("R6 deferred update flag low", drdy_n, 0);
    rd(2'd3, 16, v);
    chk("R6 deferred word landed", v, 16'h5A0F);
    chk("R3 flag high after second full read", drdy_n, 1);
    cyc(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule